// File: doc/BRIEF.md
# SMM Window Access Router

This block sits in the address decode path of a memory controller hub and picks a destination for every memory request. It looks at the request address, at which agent issued the request (the processor, the PCI Express port or the south-bridge link), and at the processor's System Management Mode state. It then decides whether the request may reach protected SMRAM in one of three windows. Those are a legacy window at 0xA0000–0xBFFFF, a high alias of that window, and an upper segment placed just under top of memory. A request that is not granted SMRAM goes to PCI Express, to the south-bridge link, to ordinary DRAM, or to an abort.

Configuration inputs do three things. They switch the three windows through a small enable matrix, in which the high window masks the legacy one. They size the upper segment. They steer the legacy range to PCI Express or to the south link when a graphics adapter sits on PCI Express. Two override bits widen SMRAM visibility ("open") or hide SMRAM data from SMM ("close"). Setting both override bits at once is illegal, and the block records it in a sticky error flag. The route is registered: it appears one clock after the request strobe, together with an output-valid flag.

Top module: `smr_router`

## Requirements
- R1: With `cfg_smram_en`=0 no window is active. A request to 0xA0000 follows the graphics rule (R5). A request to the high window goes to SOUTH (3) because it lies above top of memory. A request to the upper segment goes to DRAM (0).
- R2: With `cfg_smram_en`=1, `cfg_high_en`=0 and `cfg_seg_en`=0, only the legacy window is active. A granted access there returns SMRAM (1), and a request to the upper segment returns DRAM (0).
- R3: With `cfg_smram_en`=1, `cfg_high_en`=0 and `cfg_seg_en`=1, the legacy and upper-segment windows are active and the high window is not. A granted access returns SMRAM in both active windows, and a high-window address returns SOUTH (3).
- R4: With `cfg_smram_en`=1 and `cfg_high_en`=1, the legacy window is off and the high window (`HIGH_BASE` to `HIGH_BASE`+0x1FFFF) is on. The upper segment follows `cfg_seg_en`.
- R5: A legacy-range request that is not granted SMRAM routes to PCIE (2) when `cfg_vga_pcie`=1 and to SOUTH (3) when it is 0.
- R6: Requests with `req_src` other than 0 (1 = PCI Express, 2 = south link, 3 = reserved) never return SMRAM, whatever the enables and overrides are. In the high window and the upper segment they return ABORT (4); in the legacy range they follow R5.
- R7: A processor request (`req_src`=0) to an active window is granted SMRAM when `smm_active`=1 or `cfg_open`=1.
- R8: With `cfg_close`=1 and `cfg_open`=0, an SMM data access (`req_code`=0) is not granted. A code fetch (`req_code`=1) in SMM is still granted.
- R9: A processor request that is not granted in the active high window or upper segment returns ABORT (4).
- R10: `cfg_seg_size` encodes 0 = 1 MB, 1 = 2 MB, 2 = 8 MB and 3 = no segment. The segment covers [`TOP_OF_MEM`−size, `TOP_OF_MEM`).
- R11: Addresses outside every window route to DRAM (0) below `TOP_OF_MEM` and to SOUTH (3) at or above it. Legacy decode is checked first, then high, then segment.
- R12: `rt_valid` and `rt_route` update on the clock edge after a cycle with `req_valid`=1. In a cycle without a request, `rt_valid` falls to 0 and `rt_route` holds its value.
- R13: `cfg_err` rises on the edge after a cycle with `cfg_open`=1 and `cfg_close`=1. It stays set until reset.
- R14: Reset (`rst_n`=0, asynchronous) sets `rt_valid`=0, `rt_route`=DRAM (0) and `cfg_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Request address |
| req_src | input | 2 | Originator: 0 processor, 1 PCI Express, 2 south link, 3 reserved |
| req_code | input | 1 | 1 = code fetch, 0 = data access |
| smm_active | input | 1 | Processor is in System Management Mode |
| cfg_smram_en | input | 1 | Global SMRAM enable |
| cfg_high_en | input | 1 | High window enable |
| cfg_seg_en | input | 1 | Upper segment enable |
| cfg_seg_size | input | 2 | Upper segment size code |
| cfg_vga_pcie | input | 1 | Legacy graphics range lives on PCI Express |
| cfg_open | input | 1 | Open override: SMRAM visible outside SMM |
| cfg_close | input | 1 | Close override: SMRAM data hidden from SMM |
| rt_valid | output | 1 | Route output valid |
| rt_route | output | 3 | 0 DRAM, 1 SMRAM, 2 PCIE, 3 SOUTH, 4 ABORT |
| cfg_err | output | 1 | Sticky illegal-override flag |

## Verification
The assertions take for granted that the default window parameters keep the legacy range, the high alias and the upper segment disjoint, and that `cfg_open` and `cfg_close` are not set together while routes are being judged. The close-override property excludes the illegal combination for this reason. The stimulus table uses only legal override settings. The illegal pair is driven once, with no request pending, to exercise the error flag. Reserved originator code 3 is treated like any foreign agent, so no property has to carve it out.

// File: rtl/smr_pkg.sv
package smr_pkg;

  typedef enum logic [2:0] {
    RT_DRAM  = 3'd0,
    RT_SMRAM = 3'd1,
    RT_PCIE  = 3'd2,
    RT_SOUTH = 3'd3,
    RT_ABORT = 3'd4
  } route_t;

  typedef enum logic [1:0] {
    SRC_CPU   = 2'd0,
    SRC_PCIE  = 2'd1,
    SRC_SOUTH = 2'd2,
    SRC_RSVD  = 2'd3
  } src_t;

  typedef struct packed {
    logic legacy;
    logic high;
    logic seg;
  } win_t;

  localparam logic [63:0] LEGACY_BASE = 64'h0000_0000_000A_0000;
  localparam logic [63:0] LEGACY_SPAN = 64'h0000_0000_0002_0000;

  // Upper segment size in bytes from its 2-bit code; code 3 yields no window.
  function automatic logic [63:0] seg_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 64'h0000_0000_0010_0000;
      2'd1:    return 64'h0000_0000_0020_0000;
      2'd2:    return 64'h0000_0000_0080_0000;
      default: return 64'h0;
    endcase
  endfunction

  // Half-open span test: base <= a < base + span.
  function automatic logic in_span(input logic [63:0] a,
                                   input logic [63:0] base,
                                   input logic [63:0] span);
    return (span != 64'h0) && (a >= base) && ((a - base) < span);
  endfunction

  // Processor-only SMRAM grant with both overrides.
  function automatic logic smram_grant(input src_t src, input logic smm,
                                       input logic code, input logic open_ovr,
                                       input logic close_ovr);
    return (src == SRC_CPU) && (open_ovr || (smm && (code || !close_ovr)));
  endfunction

endpackage

// File: rtl/smr_window_map.sv
module smr_window_map
  import smr_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] HIGH_BASE  = 'hFEDA_0000,
  parameter logic [ADDR_W-1:0] TOP_OF_MEM = 'h4000_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_all,
  input  logic              en_high,
  input  logic              en_seg,
  input  logic [1:0]        seg_size,
  output win_t              win_on,
  output win_t              win_hit,
  output logic              above_tom
);

  localparam logic [63:0] HIGH_W = 64'(HIGH_BASE);
  localparam logic [63:0] TOM_W  = 64'(TOP_OF_MEM);

  logic [63:0] addr_w;
  logic [63:0] seg_span;
  logic [63:0] seg_base;

  always_comb begin
    addr_w   = 64'(addr);
    seg_span = seg_bytes(seg_size);
    seg_base = TOM_W - seg_span;
  end

  // Enable matrix: high window masks the legacy window.
  always_comb begin
    win_on.legacy = en_all && !en_high;
    win_on.high   = en_all && en_high;
    win_on.seg    = en_all && en_seg;
  end

  always_comb begin
    win_hit.legacy = in_span(addr_w, LEGACY_BASE, LEGACY_SPAN);
    win_hit.high   = in_span(addr_w, HIGH_W, LEGACY_SPAN);
    win_hit.seg    = in_span(addr_w, seg_base, seg_span);
    above_tom      = addr_w >= TOM_W;
  end

endmodule

// File: rtl/smr_access_gate.sv
module smr_access_gate
  import smr_pkg::*;
(
  input  src_t src,
  input  logic smm,
  input  logic code,
  input  logic open_ovr,
  input  logic close_ovr,
  output logic grant,
  output logic foreign
);

  always_comb begin
    foreign = (src != SRC_CPU);
    grant   = smram_grant(src, smm, code, open_ovr, close_ovr);
  end

endmodule

// File: rtl/smr_route_sel.sv
module smr_route_sel
  import smr_pkg::*;
(
  input  win_t   win_on,
  input  win_t   win_hit,
  input  logic   above_tom,
  input  logic   grant,
  input  logic   vga_pcie,
  output route_t route
);

  route_t legacy_fallback;

  always_comb begin
    legacy_fallback = vga_pcie ? RT_PCIE : RT_SOUTH;
    if (win_hit.legacy) begin
      route = (win_on.legacy && grant) ? RT_SMRAM : legacy_fallback;
    end else if (win_hit.high && win_on.high) begin
      route = grant ? RT_SMRAM : RT_ABORT;
    end else if (win_hit.seg && win_on.seg) begin
      route = grant ? RT_SMRAM : RT_ABORT;
    end else if (above_tom) begin
      route = RT_SOUTH;
    end else begin
      route = RT_DRAM;
    end
  end

endmodule

// File: rtl/smr_router.sv
module smr_router
  import smr_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] HIGH_BASE  = 'hFEDA_0000,
  parameter logic [ADDR_W-1:0] TOP_OF_MEM = 'h4000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_src,
  input  logic              req_code,
  input  logic              smm_active,
  input  logic              cfg_smram_en,
  input  logic              cfg_high_en,
  input  logic              cfg_seg_en,
  input  logic [1:0]        cfg_seg_size,
  input  logic              cfg_vga_pcie,
  input  logic              cfg_open,
  input  logic              cfg_close,
  output logic              rt_valid,
  output logic [2:0]        rt_route,
  output logic              cfg_err
);

  win_t   win_on;
  win_t   win_hit;
  logic   above_tom;
  logic   gate_grant;
  logic   gate_foreign;
  route_t route_next;
  route_t route_q;

  // Named event wires for the checker.
  logic win_legacy_on;
  logic win_high_on;
  logic win_seg_on;
  logic ovr_clash;

  smr_window_map #(
    .ADDR_W    (ADDR_W),
    .HIGH_BASE (HIGH_BASE),
    .TOP_OF_MEM(TOP_OF_MEM)
  ) u_map (
    .addr     (req_addr),
    .en_all   (cfg_smram_en),
    .en_high  (cfg_high_en),
    .en_seg   (cfg_seg_en),
    .seg_size (cfg_seg_size),
    .win_on   (win_on),
    .win_hit  (win_hit),
    .above_tom(above_tom)
  );

  smr_access_gate u_gate (
    .src      (src_t'(req_src)),
    .smm      (smm_active),
    .code     (req_code),
    .open_ovr (cfg_open),
    .close_ovr(cfg_close),
    .grant    (gate_grant),
    .foreign  (gate_foreign)
  );

  smr_route_sel u_sel (
    .win_on   (win_on),
    .win_hit  (win_hit),
    .above_tom(above_tom),
    .grant    (gate_grant),
    .vga_pcie (cfg_vga_pcie),
    .route    (route_next)
  );

  always_comb begin
    win_legacy_on = win_on.legacy;
    win_high_on   = win_on.high;
    win_seg_on    = win_on.seg;
    ovr_clash     = cfg_open && cfg_close;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_valid <= 1'b0;
      route_q  <= RT_DRAM;
      cfg_err  <= 1'b0;
    end else begin
      rt_valid <= req_valid;
      if (req_valid) begin
        route_q <= route_next;
      end
      if (ovr_clash) begin
        cfg_err <= 1'b1;
      end
    end
  end

  assign rt_route = route_q;

endmodule

// File: rtl/smr_router_chk.sv
module smr_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_src,
  input logic       req_code,
  input logic       smm_active,
  input logic       cfg_smram_en,
  input logic       cfg_open,
  input logic       cfg_close,
  input logic       win_legacy_on,
  input logic       win_high_on,
  input logic       win_seg_on,
  input logic       gate_grant,
  input logic       gate_foreign,
  input logic       rt_valid,
  input logic [2:0] rt_route,
  input logic       cfg_err
);

  // R1
  all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_smram_en |-> !(win_legacy_on || win_high_on || win_seg_on));

  // R4
  high_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_high_on |-> !win_legacy_on);

  // R6
  foreign_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_src != 2'd0) |-> (gate_foreign && !gate_grant));

  // R6
  foreign_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src != 2'd0) |=> (rt_route != 3'd1));

  // R7
  no_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smm_active && !cfg_open) |-> !gate_grant);

  // R8
  close_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_close && !cfg_open && !req_code) |-> !gate_grant);

  // R12
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rt_valid);

  // R12
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rt_valid && $stable(rt_route)));

  // R13
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && cfg_close) |=> cfg_err);

  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

endmodule

bind smr_router smr_router_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_src      (req_src),
  .req_code     (req_code),
  .smm_active   (smm_active),
  .cfg_smram_en (cfg_smram_en),
  .cfg_open     (cfg_open),
  .cfg_close    (cfg_close),
  .win_legacy_on(win_legacy_on),
  .win_high_on  (win_high_on),
  .win_seg_on   (win_seg_on),
  .gate_grant   (gate_grant),
  .gate_foreign (gate_foreign),
  .rt_valid     (rt_valid),
  .rt_route     (rt_route),
  .cfg_err      (cfg_err)
);

// File: tb/smr_router_bench.sv
`timescale 1ns/100ps
module smr_router_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_src = '0;
  logic        req_code = 1'b0;
  logic        smm_active = 1'b0;
  logic        cfg_smram_en = 1'b0;
  logic        cfg_high_en = 1'b0;
  logic        cfg_seg_en = 1'b0;
  logic [1:0]  cfg_seg_size = '0;
  logic        cfg_vga_pcie = 1'b0;
  logic        cfg_open = 1'b0;
  logic        cfg_close = 1'b0;
  logic        rt_valid;
  logic [2:0]  rt_route;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  smr_router u_smr_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_src(req_src), .req_code(req_code), .smm_active(smm_active),
    .cfg_smram_en(cfg_smram_en), .cfg_high_en(cfg_high_en),
    .cfg_seg_en(cfg_seg_en), .cfg_seg_size(cfg_seg_size),
    .cfg_vga_pcie(cfg_vga_pcie), .cfg_open(cfg_open), .cfg_close(cfg_close),
    .rt_valid(rt_valid), .rt_route(rt_route), .cfg_err(cfg_err)
  );

  localparam logic O = 1'b0;
  localparam logic I = 1'b1;
  localparam logic [1:0] CPU = 2'd0, PCI = 2'd1, SL = 2'd2;
  localparam logic [2:0] RD = 3'd0, RS = 3'd1, RP = 3'd2, RL = 3'd3, RA = 3'd4;
  localparam logic [31:0] LEG = 32'h000A_0000;
  localparam logic [31:0] HB  = 32'hFEDA_0000;

  typedef struct packed {
    logic [3:0]  req;
    logic        g, h, s;
    logic [1:0]  sz;
    logic        vga, op, cl, smm, code;
    logic [1:0]  src;
    logic [31:0] addr;
    logic [2:0]  exp;
  } vec_t;

  localparam int NV = 33;
  // fields: req, global, high, seg, size, vga, open, close, smm, code, src, addr, expected
  localparam vec_t VT [NV] = '{
    '{4'd1, O,I,I, 2'd0, I,O,O, I,O, CPU, LEG,          RP}, // R1
    '{4'd1, O,I,I, 2'd0, I,O,O, I,O, CPU, HB,           RL}, // R1
    '{4'd1, O,O,I, 2'd0, O,O,O, I,O, CPU, 32'h3FF0_0000, RD}, // R1
    '{4'd2, I,O,O, 2'd0, I,O,O, I,O, CPU, LEG,          RS}, // R2
    '{4'd2, I,O,O, 2'd0, I,O,O, I,O, CPU, 32'h3FF0_0000, RD}, // R2
    '{4'd3, I,O,I, 2'd0, I,O,O, I,O, CPU, 32'h3FF0_0000, RS}, // R3
    '{4'd3, I,O,I, 2'd0, I,O,O, I,O, CPU, HB,           RL}, // R3
    '{4'd3, I,O,I, 2'd0, I,O,O, I,O, CPU, 32'h000B_FFFF, RS}, // R3
    '{4'd4, I,I,O, 2'd0, O,O,O, I,O, CPU, LEG,          RL}, // R4
    '{4'd4, I,I,O, 2'd0, O,O,O, I,O, CPU, 32'hFEDB_FFFF, RS}, // R4
    '{4'd4, I,I,O, 2'd0, O,O,O, I,O, CPU, 32'h3FF0_0000, RD}, // R4
    '{4'd4, I,I,I, 2'd0, O,O,O, I,O, CPU, 32'h3FF8_0000, RS}, // R4
    '{4'd5, I,O,O, 2'd0, I,O,O, O,O, CPU, LEG,          RP}, // R5
    '{4'd5, I,O,O, 2'd0, O,O,O, O,O, CPU, LEG,          RL}, // R5
    '{4'd6, I,O,O, 2'd0, I,O,O, I,O, PCI, LEG,          RP}, // R6
    '{4'd6, I,I,O, 2'd0, I,O,O, I,O, SL,  HB,           RA}, // R6
    '{4'd6, I,O,I, 2'd0, I,I,O, I,O, PCI, 32'h3FF0_0000, RA}, // R6
    '{4'd7, I,I,O, 2'd0, O,I,O, O,O, CPU, HB,           RS}, // R7
    '{4'd9, I,I,O, 2'd0, O,O,O, O,O, CPU, HB,           RA}, // R9
    '{4'd9, I,O,I, 2'd0, O,O,O, O,O, CPU, 32'h3FF0_0000, RA}, // R9
    '{4'd8, I,I,O, 2'd0, O,O,I, I,O, CPU, HB,           RA}, // R8
    '{4'd8, I,I,O, 2'd0, O,O,I, I,I, CPU, HB,           RS}, // R8
    '{4'd8, I,O,O, 2'd0, I,O,I, I,O, CPU, LEG,          RP}, // R8
    '{4'd10, I,O,I, 2'd1, O,O,O, I,O, CPU, 32'h3FE0_0000, RS}, // R10
    '{4'd10, I,O,I, 2'd1, O,O,O, I,O, CPU, 32'h3FDF_FFFF, RD}, // R10
    '{4'd10, I,O,I, 2'd2, O,O,O, I,O, CPU, 32'h3F80_0000, RS}, // R10
    '{4'd10, I,O,I, 2'd2, O,O,O, I,O, CPU, 32'h3F7F_FFFF, RD}, // R10
    '{4'd10, I,O,I, 2'd3, O,O,O, I,O, CPU, 32'h3FF0_0000, RD}, // R10
    '{4'd11, I,O,O, 2'd0, O,O,O, I,O, CPU, 32'h0009_FFFF, RD}, // R11
    '{4'd11, I,O,O, 2'd0, O,O,O, I,O, CPU, 32'h000C_0000, RD}, // R11
    '{4'd11, I,O,I, 2'd0, O,O,O, I,O, CPU, 32'h4000_0000, RL}, // R11
    '{4'd11, I,I,O, 2'd0, O,O,O, I,O, CPU, 32'hFEDC_0000, RL}, // R11
    '{4'd11, I,I,O, 2'd0, O,O,O, I,O, CPU, 32'hFED9_FFFF, RL}  // R11
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    cfg_smram_en = v.g;   cfg_high_en = v.h;  cfg_seg_en = v.s;
    cfg_seg_size = v.sz;  cfg_vga_pcie = v.vga;
    cfg_open = v.op;      cfg_close = v.cl;
    smm_active = v.smm;   req_code = v.code;  req_src = v.src;
    req_addr = v.addr;    req_valid = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R14: state held in reset
    chk("R14 valid in reset", 32'(rt_valid), 32'd0);
    chk("R14 route in reset", 32'(rt_route), 32'(RD));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R14 err after reset", 32'(cfg_err), 32'd0);
    chk("R14 valid after reset", 32'(rt_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VT[i]);
      @(negedge clk);
      chk($sformatf("R%0d valid vec %0d", VT[i].req, i), 32'(rt_valid), 32'd1);
      chk($sformatf("R%0d route vec %0d", VT[i].req, i), 32'(rt_route), 32'(VT[i].exp));
    end

    // R12: no request, route holds the last value (SOUTH) despite new inputs
    req_valid = 1'b0;
    req_addr = LEG; cfg_smram_en = 1'b1; cfg_high_en = 1'b0; smm_active = 1'b1; req_src = CPU;
    @(negedge clk);
    chk("R12 valid drop", 32'(rt_valid), 32'd0);
    chk("R12 route hold", 32'(rt_route), 32'(RL));
    req_valid = 1'b1;
    @(negedge clk);
    chk("R12 route update", 32'(rt_route), 32'(RS));
    req_valid = 1'b0;

    // R13: illegal override pair sets a sticky flag
    chk("R13 err clear before clash", 32'(cfg_err), 32'd0);
    cfg_open = 1'b1; cfg_close = 1'b1;
    #1;
    chk("R13 err not yet set", 32'(cfg_err), 32'd0);
    @(negedge clk);
    chk("R13 err set", 32'(cfg_err), 32'd1);
    cfg_open = 1'b0; cfg_close = 1'b0;
    repeat (3) @(negedge clk);
    chk("R13 err sticky", 32'(cfg_err), 32'd1);

    // R14: asynchronous reset clears everything
    req_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R14 err cleared", 32'(cfg_err), 32'd0);
    chk("R14 valid cleared", 32'(rt_valid), 32'd0);
    chk("R14 route cleared", 32'(rt_route), 32'(RD));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule